// File: doc/BRIEF.md
# Selectable-Interval Watchdog with Configuration Lock

This block supervises a host processor. It counts pulses of a slow timebase tick. If the host does not restart it in time, it drives an active-low alarm output low. The alarm is a pulse of fixed length that ends without any help from the host. The timeout is taken from a 2-bit interval field. Three codes give fixed intervals and the fourth turns the watchdog off. The tick counts behind each interval are worked out from a parameter that gives the tick rate in ticks per second.

The interval field and a protect-enable bit live in a small configuration register. This register models nonvolatile storage: the block reset leaves it alone, and it takes a parameterised value only at power-up. When the write-protect pin is high and the protect-enable bit is set, both fields are locked. The host can read the register back at any time. The host restarts the timer with a rising edge on the kick input.

Top module: `wdog_sel_lock`

## Requirements
- R1: The interval codes are 2'b00 = 150 ms, 2'b01 = 400 ms and 2'b10 = 800 ms. An interval in ticks is TICK_HZ*ms/1000, with a minimum of 1. Counting from a count of zero, the alarm output goes low on the clock edge of the interval's last tick that arrives with no kick.
- R2: The alarm output is active low. It stays low for the ticks of 150 ms and then returns high by itself on the edge of the last of those ticks.
- R3: When a pulse ends, the count restarts from zero. The next alarm comes one full interval later if no kick arrives.
- R4: Only a rising edge on the kick input clears the count, and the edge wins over a tick on the same edge. A kick held high does not keep clearing the count.
- R5: Kick edges that arrive while a pulse is in progress do not shorten the pulse.
- R6: Interval code 2'b11 means off. While the register holds it, the output is high at once, the counter is held at zero and no alarm occurs. Once a valid code is selected again, counting starts from zero.
- R7: While rst_n is low, the counter and the pulse are held cleared, so the output is high after the first edge in reset. The configuration register keeps its value through reset.
- R8: A write strobe loads the interval code and the protect-enable bit on the next clock edge. The write is dropped as a whole when the write-protect pin is high and the protect-enable bit is set.
- R9: After power-up the register holds INIT_SEL and protect-enable 0. The readback ports always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the timer |
| tick | input | 1 | Timebase tick, one clock wide |
| kick | input | 1 | Restart request, acted on at its rising edge |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 2 | Interval code to write |
| cfg_wpen | input | 1 | Protect-enable bit to write |
| wp_pin | input | 1 | Write-protect pin, active high |
| cfg_sel | output | 2 | Current interval code |
| cfg_pen | output | 1 | Current protect-enable bit |
| wdo_n | output | 1 | Active-low alarm pulse |

## Verification
The assertions assume that `tick` and `kick` are synchronous to `clk`, and that a tick is high for a single clock. They also assume a write strobe lasts one clock, so a write checked with `$past` sees the data of that cycle. The bench drives every input on the falling edge. It makes one-cycle ticks every fourth clock and one-cycle write strobes. It shrinks the tick rate to 100 ticks per second so that every interval ends within a few hundred clocks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_T150 = 2'b00,
    WD_T400 = 2'b01,
    WD_T800 = 2'b10,
    WD_OFF  = 2'b11
  } wd_sel_e;

  // ticks for a span of ms at a rate of hz ticks per second, never zero
  function automatic int ms_ticks(input int hz, input int ms);
    int t;
    t = (hz * ms) / 1000;
    return (t < 1) ? 1 : t;
  endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter logic [1:0] INIT_SEL = 2'b00
) (
  input  logic       clk,
  input  logic       we,
  input  logic [1:0] wsel,
  input  logic       wpen,
  input  logic       wp_pin,
  output logic [1:0] sel_q,
  output logic       pen_q,
  output logic       locked
);
  // nonvolatile model: power-up value only, no reset
  logic [1:0] sel_r = INIT_SEL;
  logic       pen_r = 1'b0;
  logic       take;

  assign locked = wp_pin & pen_r;
  assign take   = we & ~locked;

  always_ff @(posedge clk) begin
    if (take) begin
      sel_r <= wsel;
      pen_r <= wpen;
    end
  end

  assign sel_q = sel_r;
  assign pen_q = pen_r;
endmodule

// File: rtl/wdog_kick_det.sv
module wdog_kick_det (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic rise
);
  logic kick_d;

  always_ff @(posedge clk) begin
    if (!rst_n) kick_d <= 1'b0;
    else        kick_d <= kick;
  end

  assign rise = kick & ~kick_d;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CW      = 10,
  parameter int PW      = 8,
  parameter int T150    = 150,
  parameter int T400    = 400,
  parameter int T800    = 800,
  parameter int PULSE_T = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          kick_rise,
  input  logic [1:0]    sel,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] pcnt_o,
  output logic          pulse_o,
  output logic          expire_o,
  output logic          done_o,
  output logic          off_o,
  output logic [CW-1:0] limit_o
);
  import wdog_pkg::*;

  function automatic logic [CW-1:0] sel_limit(input logic [1:0] s);
    case (wd_sel_e'(s))
      WD_T150: return CW'(T150);
      WD_T400: return CW'(T400);
      WD_T800: return CW'(T800);
      default: return CW'(T800);
    endcase
  endfunction

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;
  logic          pulse_q;
  logic [CW-1:0] limit;
  logic          off;
  logic          expire;
  logic          done;

  always_comb begin
    limit  = sel_limit(sel);
    off    = (sel == WD_OFF);
    expire = !pulse_q && !off && !kick_rise && tick && (cnt_q >= limit - 1'b1);
    done   = pulse_q && !off && tick && (pcnt_q == PW'(PULSE_T - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || off) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      cnt_q <= '0;
      if (done) begin
        pulse_q <= 1'b0;
        pcnt_q  <= '0;
      end else if (tick) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end else if (kick_rise) begin
      cnt_q <= '0;
    end else if (expire) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign pcnt_o   = pcnt_q;
  assign pulse_o  = pulse_q;
  assign expire_o = expire;
  assign done_o   = done;
  assign off_o    = off;
  assign limit_o  = limit;
endmodule

// File: rtl/wdog_sel_lock.sv
module wdog_sel_lock #(
  parameter int         TICK_HZ  = 1000,
  parameter logic [1:0] INIT_SEL = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wsel,
  input  logic       cfg_wpen,
  input  logic       wp_pin,
  output logic [1:0] cfg_sel,
  output logic       cfg_pen,
  output logic       wdo_n
);
  import wdog_pkg::*;

  localparam int T150    = ms_ticks(TICK_HZ, 150);
  localparam int T400    = ms_ticks(TICK_HZ, 400);
  localparam int T800    = ms_ticks(TICK_HZ, 800);
  localparam int PULSE_T = ms_ticks(TICK_HZ, 150);
  localparam int CW      = $clog2(T800 + 1);
  localparam int PW      = $clog2(PULSE_T + 1);

  logic [1:0]    sel_w;
  logic          pen_w;
  logic          locked;
  logic          kick_rise;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic          pulse;
  logic          expire;
  logic          done;
  logic          off;
  logic [CW-1:0] limit;

  wdog_cfg_reg #(.INIT_SEL(INIT_SEL)) u_cfg (
    .clk(clk), .we(cfg_we), .wsel(cfg_wsel), .wpen(cfg_wpen),
    .wp_pin(wp_pin), .sel_q(sel_w), .pen_q(pen_w), .locked(locked)
  );

  wdog_kick_det u_kick (
    .clk(clk), .rst_n(rst_n), .kick(kick), .rise(kick_rise)
  );

  wdog_timer #(
    .CW(CW), .PW(PW), .T150(T150), .T400(T400), .T800(T800), .PULSE_T(PULSE_T)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick_rise(kick_rise), .sel(sel_w),
    .cnt_o(cnt), .pcnt_o(pcnt), .pulse_o(pulse), .expire_o(expire),
    .done_o(done), .off_o(off), .limit_o(limit)
  );

  assign cfg_sel = sel_w;
  assign cfg_pen = pen_w;
  assign wdo_n   = ~(pulse & ~off);
endmodule

// File: rtl/wdog_sel_lock_chk.sv
module wdog_sel_lock_chk #(
  parameter int CW      = 10,
  parameter int PW      = 8,
  parameter int PULSE_T = 150
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_wsel,
  input logic          cfg_wpen,
  input logic          wp_pin,
  input logic [1:0]    cfg_sel,
  input logic          cfg_pen,
  input logic          wdo_n,
  input logic          kick_rise,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] pcnt,
  input logic          pulse,
  input logic          expire,
  input logic          off
);
  AST_EXPIRE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg_we) |=> !wdo_n); // R1
  AST_LOW_MEANS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !wdo_n |-> pulse); // R2
  AST_PULSE_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> (cnt == '0)); // R3
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_rise && !pulse) |=> (cnt == '0)); // R4
  AST_PULSE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !off && (pcnt != PW'(PULSE_T - 1))) |=> pulse); // R5
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> ((cnt == '0) && !pulse)); // R6
  AST_RESET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((cnt == '0) && wdo_n)); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wp_pin && cfg_pen) |=> ($stable(cfg_sel) && $stable(cfg_pen))); // R8
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(wp_pin && cfg_pen)) |=>
      ((cfg_sel == $past(cfg_wsel)) && (cfg_pen == $past(cfg_wpen)))); // R8
endmodule

bind wdog_sel_lock wdog_sel_lock_chk #(.CW(CW), .PW(PW), .PULSE_T(PULSE_T)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
  .cfg_wpen(cfg_wpen), .wp_pin(wp_pin), .cfg_sel(cfg_sel), .cfg_pen(cfg_pen),
  .wdo_n(wdo_n), .kick_rise(kick_rise), .cnt(cnt), .pcnt(pcnt), .pulse(pulse),
  .expire(expire), .off(off)
);

// File: tb/wdog_sel_lock_test.sv
`timescale 1ns/1ps
module wdog_sel_lock_test;
  localparam int HZ = 100;
  localparam int L150 = HZ * 150 / 1000;
  localparam int L400 = HZ * 400 / 1000;
  localparam int L800 = HZ * 800 / 1000;

  logic clk = 0, rst_n = 0, tick = 0, kick = 0;
  logic cfg_we = 0, cfg_wpen = 0, wp_pin = 0;
  logic [1:0] cfg_wsel = 0;
  logic [1:0] cfg_sel;
  logic cfg_pen, wdo_n;
  int checks = 0, errors = 0;
  int tdiv = 0;
  bit done_run = 0;

  wdog_sel_lock #(.TICK_HZ(HZ), .INIT_SEL(2'b00)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .cfg_we(cfg_we),
    .cfg_wsel(cfg_wsel), .cfg_wpen(cfg_wpen), .wp_pin(wp_pin),
    .cfg_sel(cfg_sel), .cfg_pen(cfg_pen), .wdo_n(wdo_n)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  // behavioural reference
  int m_sel = 0, m_pen = 0, m_cnt = 0, m_pc = 0, m_pulse = 0, m_kp = 0;
  function automatic int lim_of(int s);
    if (s == 0) return L150;
    if (s == 1) return L400;
    return L800;
  endfunction

  always @(posedge clk) begin
    int rise;
    rise = (kick && !m_kp) ? 1 : 0;
    if (!rst_n || m_sel == 3) begin
      m_cnt = 0; m_pc = 0; m_pulse = 0;
    end else if (m_pulse != 0) begin
      if (tick) begin
        m_pc++;
        if (m_pc == L150) begin m_pulse = 0; m_pc = 0; end
      end
    end else if (rise != 0) begin
      m_cnt = 0;
    end else if (tick) begin
      m_cnt++;
      if (m_cnt >= lim_of(m_sel)) begin m_cnt = 0; m_pulse = 1; m_pc = 0; end
    end
    m_kp = rst_n ? int'(kick) : 0;
    if (cfg_we && !(wp_pin && m_pen != 0)) begin
      m_sel = int'(cfg_wsel); m_pen = int'(cfg_wpen);
    end
  end

  always @(negedge clk) begin
    if (!done_run) begin
      checks++;
      if (wdo_n != !(m_pulse != 0 && m_sel != 3)) begin
        errors++;
        $display("FAIL R2 model compare wdo_n actual=%0d expected=%0d t=%0t",
                 wdo_n, !(m_pulse != 0 && m_sel != 3), $time);
      end
      checks++;
      if (int'(cfg_sel) != m_sel || int'(cfg_pen) != m_pen) begin
        errors++;
        $display("FAIL R8 model compare cfg actual=%0d/%0d expected=%0d/%0d",
                 cfg_sel, cfg_pen, m_sel, m_pen);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick_edge();
    @(negedge clk) kick = 1;
    @(negedge clk) kick = 0;
  endtask

  task automatic write_cfg(input logic [1:0] s, input logic p);
    @(negedge clk) begin cfg_we = 1; cfg_wsel = s; cfg_wpen = p; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic count_to(input logic lvl, input bit tog, output int n);
    n = 0;
    while (1) begin
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
      if (tog) kick = ~kick;
      if (wdo_n == lvl || n > 2000) break;
    end
    kick = 0;
  endtask

  task automatic wait_ticks(input int k);
    int n = 0;
    while (n < k) begin
      @(posedge clk);
      if (tick) n++;
    end
    @(negedge clk);
  endtask

  initial begin
    int n;
    bit stay;
    repeat (4) @(negedge clk);
    chk(wdo_n == 1, "R7 output high in reset", wdo_n, 1);
    chk(cfg_sel == 2'b00 && cfg_pen == 0, "R9 power-up register", cfg_sel, 0);
    rst_n = 1;
    kick_edge();
    count_to(0, 0, n); chk(n == L150, "R1 interval 00", n, L150);
    count_to(1, 0, n); chk(n == L150, "R2 pulse length", n, L150);
    count_to(0, 0, n); chk(n == L150, "R3 restart after pulse", n, L150);
    count_to(1, 1, n); chk(n == L150, "R5 kicks during pulse", n, L150);

    write_cfg(2'b01, 0);
    chk(cfg_sel == 2'b01, "R8 write takes", cfg_sel, 1);
    kick_edge();
    count_to(0, 0, n); chk(n == L400, "R1 interval 01", n, L400);
    count_to(1, 0, n);
    write_cfg(2'b10, 0);
    kick_edge();
    count_to(0, 0, n); chk(n == L800, "R1 interval 10", n, L800);
    count_to(1, 0, n);

    write_cfg(2'b00, 0);
    kick_edge();
    wait_ticks(10);
    kick_edge();
    count_to(0, 0, n); chk(n == L150, "R4 kick mid-count clears", n, L150);
    count_to(1, 0, n);
    @(negedge clk) kick = 1;
    count_to(0, 0, n); chk(n == L150, "R4 held kick no re-clear", n, L150);
    count_to(1, 0, n);

    count_to(0, 0, n);
    write_cfg(2'b11, 0);
    chk(wdo_n == 1, "R6 off forces high at once", wdo_n, 1);
    stay = 1;
    repeat (200) @(negedge clk) if (!wdo_n) stay = 0;
    chk(stay, "R6 no alarm while off", stay, 1);
    write_cfg(2'b00, 0);
    count_to(0, 0, n); chk(n == L150, "R6 counts from zero after off", n, L150);
    count_to(1, 0, n);

    write_cfg(2'b00, 1);
    wp_pin = 1;
    write_cfg(2'b11, 0);
    chk(cfg_sel == 2'b00 && cfg_pen == 1, "R8 locked write dropped", cfg_sel, 0);
    wp_pin = 0;
    write_cfg(2'b01, 0);
    chk(cfg_sel == 2'b01 && cfg_pen == 0, "R9 readback after unlock", cfg_sel, 1);

    kick_edge();
    wait_ticks(30);
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    chk(cfg_sel == 2'b01, "R7 register kept in reset", cfg_sel, 1);
    rst_n = 1;
    count_to(0, 0, n); chk(n == L400, "R7 count cleared by reset", n, L400);
    rst_n = 0;
    @(negedge clk);
    chk(wdo_n == 1, "R7 reset ends pulse", wdo_n, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done_run = 1;
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule